// File: doc/BRIEF.md
# Prescaled Watchdog Timer

A watchdog for a small 8-bit controller. The oscillator clock runs through a fixed divide-by-12 stage, which marks instruction-cycle boundaries. It then runs through a prescaler with eight selectable ratios, from 2 to 256, and finally drives a timer that is `TIMER_W` bits wide. When that timer wraps, the block raises a reset pulse for the rest of the chip, but only if the watchdog is enabled.

Software controls the block through one byte-wide control register at a single decoded address. The register holds:

- an enable bit;
- a self-clearing restart bit, which zeroes the prescaler and the timer at the next instruction-cycle boundary;
- a run-in-idle bit, which decides whether the idle-mode input freezes the whole divider chain;
- a three-bit ratio select.

The reset pulse also returns the control register to its reset value.

Top module: `wdog_top`

## Requirements
- R1: After `rst_ni` is released, `wdt_rst_o` is 0, the control register reads 0x00, and the divide-by-12 counter, the prescaler and the timer all start from zero.
- R2: With enable set, the first `wdt_rst_o` pulse appears exactly `BASE_DIV * ratio * 2^TIMER_W` clock edges after counting starts. The ratio select field (bits 2:0) maps 000→2, 010→4, 001→8, 011→16, 100→32, 101→64, 110→128 and 111→256.
- R3: Writing 1 to bit 6 (restart) zeroes the prescaler and the timer at the next edge on which the divide-by-12 stage completes a cycle. A restart written at the first edge after reset therefore delays the timeout by `BASE_DIV` edges.
- R4: Bit 6 clears itself. Reads return 0 in bit 6 and in unused bits 4:3.
- R5: A read at the control address returns bit 7 = enable, bit 5 = run-in-idle and bits 2:0 = ratio select, as last written.
- R6: While `idle_i` is 1 and run-in-idle is 0, the divider, the prescaler and the timer hold their values, so the timeout is delayed by the number of edges spent in that state.
- R7: While run-in-idle is 1, `idle_i` has no effect on the timeout.
- R8: With enable 0, a timer wrap produces no `wdt_rst_o` pulse.
- R9: `wdt_rst_o` is high for exactly one clock, and the edge that ends it clears the control register to 0x00.
- R10: Writes to any address other than `CTRL_ADDR` are ignored, and `rdata_o` is 0x00 when `addr_i` differs from `CTRL_ADDR`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data; combinational from `addr_i` |
| idle_i | input | 1 | Idle-mode indication |
| wdt_rst_o | output | 1 | One-clock reset request |

## Verification
The timeout is counted in clock edges from the edge that writes the control register, which is the first edge after reset is released. The pulse is due in the cycle after edge `BASE_DIV * ratio * 2^TIMER_W`, because one output register follows the combinational wrap detect. A restart adds `BASE_DIV` edges, and an idle stall adds one edge per stalled edge. The bench counts edges and samples on the falling edge. It records the first edge at which the pulse is seen, checks that the pulse is gone one edge later, and then reads the register back combinationally. All eight ratio codes are swept on a 3-bit timer so that every timeout fits in the run.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned CTRL_EN_BIT   = 7;
  localparam int unsigned CTRL_CLR_BIT  = 6;
  localparam int unsigned CTRL_IDLE_BIT = 5;
  localparam int unsigned SEL_W         = 3;
  localparam int unsigned SHIFT_W       = 4;

  // ratio = 2**shift; codes 001 and 010 are swapped against binary order
  function automatic logic [SHIFT_W-1:0] sel_to_shift(input logic [SEL_W-1:0] sel);
    unique case (sel)
      3'b001:  sel_to_shift = 4'd3;
      3'b010:  sel_to_shift = 4'd2;
      default: sel_to_shift = {1'b0, sel} + 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/wdog_div.sv
module wdog_div #(
  parameter int unsigned BASE_DIV = 12,
  localparam int unsigned CNT_W   = $clog2(BASE_DIV)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  logic [CNT_W-1:0] cnt_q;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BASE_DIV - 1);

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_presc.sv
module wdog_presc #(
  parameter int unsigned PRE_W   = 8,
  localparam int unsigned SHIFT_W = wdog_pkg::SHIFT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clr_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic [PRE_W-1:0]   cnt_o,
  output logic               tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W:0]   lim;
  logic             wrap;

  assign lim    = ((PRE_W+1)'(1) << shift_i) - 1'b1;
  // >= so that a smaller ratio chosen mid-count still wraps at once
  assign wrap   = ({1'b0, cnt_q} >= lim);
  assign tick_o = tick_i && !clr_i && wrap;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) begin
      if (clr_i || wrap) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int unsigned TIMER_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               clr_i,
  output logic [TIMER_W-1:0] cnt_o,
  output logic               ovf_o
);
  logic [TIMER_W-1:0] cnt_q;

  assign ovf_o = tick_i && (&cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             div_tick_i,
  input  logic             wdt_rst_i,
  output logic             en_o,
  output logic             idle_run_o,
  output logic [SEL_W-1:0] sel_o,
  output logic             clr_do_o,
  output logic [7:0]       view_o
);
  logic             en_q, idle_run_q, pend_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      idle_run_q <= 1'b0;
      sel_q      <= '0;
    end else if (wdt_rst_i) begin
      en_q       <= 1'b0;
      idle_run_q <= 1'b0;
      sel_q      <= '0;
    end else if (wr_i) begin
      en_q       <= wdata_i[CTRL_EN_BIT];
      idle_run_q <= wdata_i[CTRL_IDLE_BIT];
      sel_q      <= wdata_i[SEL_W-1:0];
    end
  end

  // restart request waits for the next instruction-cycle boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             pend_q <= 1'b0;
    else if (wdt_rst_i)                      pend_q <= 1'b0;
    else if (wr_i && wdata_i[CTRL_CLR_BIT])  pend_q <= 1'b1;
    else if (div_tick_i)                     pend_q <= 1'b0;
  end

  assign clr_do_o   = div_tick_i && pend_q;
  assign en_o       = en_q;
  assign idle_run_o = idle_run_q;
  assign sel_o      = sel_q;

  always_comb begin
    view_o                = '0;
    view_o[CTRL_EN_BIT]   = en_q;
    view_o[CTRL_IDLE_BIT] = idle_run_q;
    view_o[SEL_W-1:0]     = sel_q;
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_DIV        = 12,
  parameter int unsigned TIMER_W         = 14,
  parameter int unsigned PRE_W           = 8,
  parameter int unsigned ADDR_W          = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h4C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              idle_i,
  output logic              wdt_rst_o
);
  logic               hit, run, div_tick, pre_tick, ovf, clr_do;
  logic               en, idle_run;
  logic [SEL_W-1:0]   sel;
  logic [7:0]         view;
  logic [PRE_W-1:0]   pre_cnt;
  logic [TIMER_W-1:0] tmr_cnt;
  logic               rst_q;

  assign hit = (addr_i == CTRL_ADDR);
  assign run = !idle_i || idle_run;

  wdog_ctrl i_ctrl (
    .clk_i, .rst_ni,
    .wr_i       (wr_i && hit),
    .wdata_i,
    .div_tick_i (div_tick),
    .wdt_rst_i  (rst_q),
    .en_o       (en),
    .idle_run_o (idle_run),
    .sel_o      (sel),
    .clr_do_o   (clr_do),
    .view_o     (view)
  );

  wdog_div #(.BASE_DIV(BASE_DIV)) i_div (
    .clk_i, .rst_ni, .run_i(run), .tick_o(div_tick)
  );

  wdog_presc #(.PRE_W(PRE_W)) i_presc (
    .clk_i, .rst_ni,
    .tick_i  (div_tick),
    .clr_i   (clr_do),
    .shift_i (sel_to_shift(sel)),
    .cnt_o   (pre_cnt),
    .tick_o  (pre_tick)
  );

  wdog_timer #(.TIMER_W(TIMER_W)) i_timer (
    .clk_i, .rst_ni,
    .tick_i (pre_tick),
    .clr_i  (clr_do),
    .cnt_o  (tmr_cnt),
    .ovf_o  (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b0;
    else         rst_q <= ovf && en;
  end

  assign wdt_rst_o = rst_q;
  assign rdata_o   = hit ? view : 8'h00;
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int unsigned TIMER_W = 14,
  parameter int unsigned PRE_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               idle_i,
  input logic               wdt_rst_o,
  input logic [7:0]         rdata_o,
  input logic               en,
  input logic               idle_run,
  input logic [7:0]         view,
  input logic [PRE_W-1:0]   pre_cnt,
  input logic [TIMER_W-1:0] tmr_cnt
);
  // R9
  pulse_one_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);
  // R9
  ctrl_wiped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> (view == 8'h00));
  // R8
  rst_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdt_rst_o) |-> $past(en));
  // R6
  idle_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && !idle_run) |=> ($stable(tmr_cnt) && $stable(pre_cnt)));
  // R4
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[6] == 1'b0 && rdata_o[4:3] == 2'b00);
endmodule

bind wdog_top wdog_chk #(.TIMER_W(TIMER_W), .PRE_W(PRE_W)) i_wdog_chk (
  .clk_i, .rst_ni, .idle_i, .wdt_rst_o, .rdata_o,
  .en, .idle_run, .view, .pre_cnt, .tmr_cnt
);

// File: tb/test_wdog_top.sv
module test_wdog_top;
  localparam int unsigned BASE_DIV = 12;
  localparam int unsigned TIMER_W  = 3;
  localparam logic [7:0]  ADDR     = 8'h4C;

  logic       clk = 1'b0, rst_n = 1'b0, wr = 1'b0, idle = 1'b0;
  logic [7:0] addr = ADDR, wdata = 8'h00, rdata;
  logic       wdt_rst;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  wdog_top #(.BASE_DIV(BASE_DIV), .TIMER_W(TIMER_W)) i_wdog_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .idle_i(idle), .wdt_rst_o(wdt_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ratio_of(input logic [2:0] s);
    case (s)
      3'b000: return 2;   3'b010: return 4;   3'b001: return 8;   3'b011: return 16;
      3'b100: return 32;  3'b101: return 64;  3'b110: return 128; default: return 256;
    endcase
  endfunction

  // resets, writes data at edge 1, optionally holds idle over edges 2..idle_len+1,
  // returns the edge after which the pulse was first seen (-1 if none)
  task automatic run_case(input logic [7:0] d, input int idle_len, input int limit,
                          output int seen, output bit wide);
    seen = -1; wide = 0;
    rst_n = 1'b0; wr = 1'b0; idle = 1'b0; addr = ADDR;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; wr = 1'b1; wdata = d;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
      idle = (idle_len > 0) && (k >= 1) && (k <= idle_len);
      if (wdt_rst) begin
        if (seen < 0) seen = k;
        else wide = 1;
      end
      if (seen >= 0 && k == seen + 1) break;
    end
    idle = 1'b0;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int seen, exp;
    bit wide;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(rdata == 8'h00, "R1 ctrl reset", rdata, 0);
    chk(wdt_rst == 1'b0, "R1 pulse low in reset", wdt_rst, 0);

    // R2 sweep over every ratio code, R9 pulse width and register wipe
    for (int s = 0; s < 8; s++) begin
      exp = BASE_DIV * ratio_of(3'(s)) * (1 << TIMER_W);
      run_case(8'h80 | 8'(s), 0, exp + 30, seen, wide);
      chk(seen == exp, "R2 timeout edge", seen, exp);
      chk(!wide, "R9 single-clock pulse", wide, 0);
      chk(rdata == 8'h00, "R9 ctrl cleared after pulse", rdata, 0);
    end

    // R3 restart written with config delays by one instruction cycle
    for (int s = 0; s < 3; s++) begin
      exp = BASE_DIV + BASE_DIV * ratio_of(3'(s)) * (1 << TIMER_W);
      run_case(8'hC0 | 8'(s), 0, exp + 30, seen, wide);
      chk(seen == exp, "R3 restart delay", seen, exp);
    end

    // R6 idle stall for 100 edges, R7 idle ignored when run-in-idle set
    exp = BASE_DIV * 2 * (1 << TIMER_W);
    run_case(8'h80, 100, exp + 130, seen, wide);
    chk(seen == exp + 100, "R6 idle freezes chain", seen, exp + 100);
    run_case(8'hA0, 100, exp + 130, seen, wide);
    chk(seen == exp, "R7 run-in-idle", seen, exp);

    // R8 disabled watchdog never pulses
    run_case(8'h00, 0, exp + 60, seen, wide);
    chk(seen == -1, "R8 no pulse when disabled", seen, -1);

    // R4 / R5 readback layout, R10 other address
    run_case(8'hFF, 0, 3, seen, wide);
    chk(rdata == 8'hA7, "R4 R5 readback of 0xFF", rdata, 8'hA7);
    addr = 8'h4D;
    @(negedge clk);
    chk(rdata == 8'h00, "R10 read other address", rdata, 0);
    wr = 1'b1; wdata = 8'h22;
    @(negedge clk);
    wr = 1'b0; addr = ADDR;
    @(negedge clk);
    chk(rdata == 8'hA7, "R10 foreign write ignored", rdata, 8'hA7);
    wr = 1'b1; wdata = 8'h2B;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
    chk(rdata == 8'h23, "R5 field positions", rdata, 8'h23);
    // R10 foreign write does not arm watchdog
    run_case(8'h00, 0, 2, seen, wide);
    addr = 8'h11; wr = 1'b1; wdata = 8'h80;
    @(negedge clk);
    wr = 1'b0; addr = ADDR;
    repeat (exp + 20) @(negedge clk) if (wdt_rst) seen = 1;
    chk(seen == -1, "R10 no pulse after foreign write", seen, -1);

    // R1: reset returns register to zero
    rst_n = 1'b0;
    @(negedge clk);
    chk(rdata == 8'h00 && wdt_rst == 1'b0, "R1 re-reset", rdata, 0);
    rst_n = 1'b1;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule